// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Preamble and Break Generation

This block is the transmit half of an asynchronous serial port. Software loads a word into a single-entry holding register. At the next frame boundary the transmitter moves the word into a shift register and sends it on the serial line, least significant bit first, framed by a start bit (0) and one stop bit (1). Each bit lasts one period of an externally supplied baud tick. The word length is 8 or 9 data bits, chosen by an input pin when each frame is loaded.

Besides data, the transmitter makes two special frames. An idle preamble is a full frame of ones. It is queued each time the transmitter enable rises. A break is a full frame of zeros, stop position included. After the last of one or more breaks, a single mark bit (1) follows. The serial output comes with a drive-enable pin. The line is left undriven only when the transmitter is disabled and no frame is in flight.

Two flags are exposed. The holding-register-empty flag shows that the holding register may be written. The transmit-complete flag shows that the line has gone quiet. An interrupt request combines each flag with its own enable.

Top module: `sertx_top`

## Requirements
- R1: After reset, dataEmpty=1, txDone=1 and txLine=1. With txEnable=0, txDriveEn=0, and with both interrupt enables at 0, irq=0.
- R2: A data frame is sent one bit per baudTick, in this order: start bit 0, data bits LSB first, stop bit 1. It carries 8 data bits (10 bits in total) when longWord=0, or 9 data bits (11 bits in total) when longWord=1.
- R3: A wrEn pulse changes wrData's capture and clears dataEmpty only when a statusRd pulse came in an earlier cycle and no write has come since. A write without that earlier status read has no effect.
- R4: A written word starts only at a frame boundary, on a baudTick that ends the last bit in flight or falls while the line is idle. dataEmpty returns to 1 in the cycle the word starts. A word written while the previous one is in flight waits for it to finish.
- R5: txDone is set when the last bit of a frame finishes and nothing else starts. It is cleared by the same status-read-then-write sequence that clears dataEmpty.
- R6: Each rising edge of txEnable queues one preamble: 10 ones when longWord=0, or 11 ones when longWord=1. If a frame is in flight, the preamble follows it.
- R7: When txEnable falls, the frame in flight completes and no new frame starts. Once the line is idle with txEnable=0, txDriveEn goes to 0.
- R8: While sendBreak is held at 1, the transmitter sends back-to-back whole break frames, with every bit at 0 including the stop position.
- R9: If sendBreak rises and falls again before the frame in flight ends, exactly one break frame follows that frame.
- R10: After the last break frame, a single 1 bit is sent before any other frame.
- R11: When several items wait at a frame boundary, they start in this order: break, then the trailing mark bit, then the preamble, then the held data word.
- R12: irq = (txIntEn AND dataEmpty) OR (doneIntEn AND txDone).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse marking each bit period |
| longWord | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| statusRd | input | 1 | Status read strobe that arms a data write |
| wrEn | input | 1 | Data write strobe |
| wrData | input | 9 | Word to transmit (bit 8 used only with longWord=1) |
| txEnable | input | 1 | Transmitter enable |
| sendBreak | input | 1 | Break request |
| txIntEn | input | 1 | Interrupt enable for dataEmpty |
| doneIntEn | input | 1 | Interrupt enable for txDone |
| txLine | output | 1 | Serial output, high when idle |
| txDriveEn | output | 1 | Drive enable for the serial output |
| dataEmpty | output | 1 | Holding register empty flag |
| txDone | output | 1 | Transmission complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that baudTick is a single-cycle pulse and that wrEn and statusRd are single-cycle strobes that never occur in the same cycle. They also assume that control inputs change only between clock edges. The bench drives every input on the falling clock edge. It makes its baud tick one cycle in four, and it always separates the status read from the write by one cycle. Enable and break changes are placed both inside frames and at idle, so that the queued-item ordering is exercised under these assumptions.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // strobes issued by the sequencer to the datapath, at most one load per cycle
  typedef struct packed {
    logic shift;
    logic loadData;
    logic loadPre;
    logic loadBrk;
    logic loadMark;
    logic goIdle;
  } txStrb_t;
endpackage

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int FRAME_W = DATA_W + 2,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrb_t           strb,
  input  logic              longWord,
  input  logic              wrLatch,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cntQ,
  output logic              lineBit
);
  logic [DATA_W-1:0]  holdQ;
  logic [FRAME_W-1:0] shiftQ;
  logic [FRAME_W-1:0] dataFrame;
  logic [CNT_W-1:0]   frameLen;

  assign frameLen = longWord ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);

  always_comb begin
    dataFrame = '1;
    dataFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < DATA_W - 1 || longWord) dataFrame[i+1] = holdQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdQ <= '0;
    else if (wrLatch) holdQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '1;
      cntQ   <= '0;
    end else if (strb.loadData) begin
      shiftQ <= dataFrame;
      cntQ   <= frameLen;
    end else if (strb.loadPre) begin
      shiftQ <= '1;
      cntQ   <= frameLen;
    end else if (strb.loadBrk) begin
      shiftQ <= '0;
      cntQ   <= frameLen;
    end else if (strb.loadMark) begin
      shiftQ <= '1;
      cntQ   <= CNT_W'(1);
    end else if (strb.shift) begin
      shiftQ <= {1'b1, shiftQ[FRAME_W-1:1]};
      cntQ   <= cntQ - CNT_W'(1);
    end else if (strb.goIdle) begin
      shiftQ <= '1;
      cntQ   <= '0;
    end
  end

  assign lineBit = (cntQ != '0) ? shiftQ[0] : 1'b1;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(FRAME_W));

  // R8: while a break frame is in flight its bits are all zero
  assert_break_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBrk |=> (lineBit == 1'b0));
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int FRAME_W = DATA_W + 2,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             statusRd,
  input  logic             wrEn,
  input  logic             txEnable,
  input  logic             sendBreak,
  input  logic             txIntEn,
  input  logic             doneIntEn,
  input  logic [CNT_W-1:0] cntQ,
  output txStrb_t          strb,
  output logic             wrLatch,
  output logic             tdreQ,
  output logic             tcQ,
  output logic             irq
);
  logic armQ, enPrevQ, brkPrevQ, preQ, brkQ, markQ;
  logic boundary, brkWant, enRise, brkRise, lastBit;

  assign lastBit  = (cntQ == CNT_W'(1));
  assign boundary = baudTick && (cntQ <= CNT_W'(1));
  assign brkWant  = sendBreak || brkQ;
  assign enRise   = txEnable && !enPrevQ;
  assign brkRise  = sendBreak && !brkPrevQ;
  assign wrLatch  = wrEn && armQ;

  always_comb begin
    strb = '0;
    strb.shift = baudTick && (cntQ > CNT_W'(1));
    if (boundary) begin
      if (txEnable && brkWant)     strb.loadBrk  = 1'b1;
      else if (txEnable && markQ)  strb.loadMark = 1'b1;
      else if (txEnable && preQ)   strb.loadPre  = 1'b1;
      else if (txEnable && !tdreQ) strb.loadData = 1'b1;
      else                         strb.goIdle   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ <= 1'b0; enPrevQ <= 1'b0; brkPrevQ <= 1'b0;
      preQ <= 1'b0; brkQ <= 1'b0; markQ <= 1'b0;
      tdreQ <= 1'b1; tcQ <= 1'b1;
    end else begin
      armQ     <= statusRd || (armQ && !wrEn);
      enPrevQ  <= txEnable;
      brkPrevQ <= sendBreak;
      if (enRise) preQ <= 1'b1;
      else if (strb.loadPre) preQ <= 1'b0;
      if (strb.loadBrk) brkQ <= 1'b0;
      else if (brkRise) brkQ <= 1'b1;
      if (strb.loadBrk) markQ <= 1'b1;
      else if (strb.loadMark) markQ <= 1'b0;
      if (wrLatch) tdreQ <= 1'b0;
      else if (strb.loadData) tdreQ <= 1'b1;
      if (wrLatch) tcQ <= 1'b0;
      else if (strb.goIdle && lastBit) tcQ <= 1'b1;
    end
  end

  assign irq = (txIntEn && tdreQ) || (doneIntEn && tcQ);

  assert_one_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadData, strb.loadPre, strb.loadBrk, strb.loadMark, strb.goIdle}));

  assert_tdre_clear_seq_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tdreQ) |-> $past(wrEn && armQ));

  assert_tc_when_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tcQ) |-> (cntQ == '0));

  assert_tick_paced_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntQ) |-> $past(baudTick));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int FRAME_W = DATA_W + 2,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              longWord,
  input  logic              statusRd,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEnable,
  input  logic              sendBreak,
  input  logic              txIntEn,
  input  logic              doneIntEn,
  output logic              txLine,
  output logic              txDriveEn,
  output logic              dataEmpty,
  output logic              txDone,
  output logic              irq
);
  txStrb_t          strb;
  logic             wrLatch;
  logic [CNT_W-1:0] cntQ;

  sertx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .statusRd(statusRd),
    .wrEn(wrEn), .txEnable(txEnable), .sendBreak(sendBreak),
    .txIntEn(txIntEn), .doneIntEn(doneIntEn), .cntQ(cntQ), .strb(strb),
    .wrLatch(wrLatch), .tdreQ(dataEmpty), .tcQ(txDone), .irq(irq)
  );

  sertx_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .longWord(longWord),
    .wrLatch(wrLatch), .wrData(wrData), .cntQ(cntQ), .lineBit(txLine)
  );

  assign txDriveEn = txEnable || (cntQ != '0);

  // R7: the line is released only after the frame in flight is done
  assert_release_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDriveEn) |-> (txLine == 1'b1));
endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, baudTick = 1'b0, longWord = 1'b0;
  logic statusRd = 1'b0, wrEn = 1'b0, txEnable = 1'b0, sendBreak = 1'b0;
  logic txIntEn = 1'b0, doneIntEn = 1'b0;
  logic [8:0] wrData = '0;
  logic txLine, txDriveEn, dataEmpty, txDone, irq;

  int checks = 0, failures = 0, cycles = 0, divCnt = 0;
  string phase = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_top u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .longWord(longWord),
    .statusRd(statusRd), .wrEn(wrEn), .wrData(wrData), .txEnable(txEnable),
    .sendBreak(sendBreak), .txIntEn(txIntEn), .doneIntEn(doneIntEn),
    .txLine(txLine), .txDriveEn(txDriveEn), .dataEmpty(dataEmpty),
    .txDone(txDone), .irq(irq)
  );

  // baud tick: one cycle in four
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 4;
    baudTick <= (divCnt == 0);
  end

  // behavioural reference model
  bit mQ[$];
  bit mTdre, mTc, mArm, mPre, mBrk, mMark, mEnPrev, mBkPrev;
  logic [8:0] mHold;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit riseEn, riseBk, loadB, last;
    int len;
    if (!rstN) begin
      mQ.delete(); mTdre = 1; mTc = 1; mArm = 0; mPre = 0; mBrk = 0;
      mMark = 0; mEnPrev = 0; mBkPrev = 0; mHold = '0;
    end else begin
      riseEn = txEnable && !mEnPrev;
      riseBk = sendBreak && !mBkPrev;
      loadB = 0;
      if (baudTick) begin
        if (mQ.size() > 1) void'(mQ.pop_front());
        else begin
          last = (mQ.size() == 1);
          len = longWord ? 11 : 10;
          mQ.delete();
          if (txEnable && (sendBreak || mBrk)) begin
            repeat (len) mQ.push_back(1'b0);
            mBrk = 0; mMark = 1; loadB = 1;
          end else if (txEnable && mMark) begin
            mQ.push_back(1'b1); mMark = 0;
          end else if (txEnable && mPre) begin
            repeat (len) mQ.push_back(1'b1);
            mPre = 0;
          end else if (txEnable && !mTdre) begin
            mQ.push_back(1'b0);
            for (int i = 0; i < len - 2; i++) mQ.push_back(mHold[i]);
            mQ.push_back(1'b1);
            mTdre = 1;
          end else if (last) mTc = 1;
        end
      end
      if (riseEn) mPre = 1;
      if (riseBk && !loadB) mBrk = 1;
      if (wrEn && mArm) begin mHold = wrData; mTdre = 0; mTc = 0; end
      mArm = statusRd || (mArm && !wrEn);
      mEnPrev = txEnable; mBkPrev = sendBreak;
    end
    #2;
    if (rstN && !finished) begin
      logic expLine, expDrv, expIrq;
      expLine = (mQ.size() != 0) ? mQ[0] : 1'b1;
      expDrv = txEnable || (mQ.size() != 0);
      expIrq = (txIntEn && mTdre) || (doneIntEn && mTc);
      check({txLine, txDriveEn, dataEmpty, txDone, irq} ===
            {expLine, expDrv, mTdre, mTc, expIrq}, phase,
            $sformatf("%b", {txLine, txDriveEn, dataEmpty, txDone, irq}),
            $sformatf("%b", {expLine, expDrv, mTdre, mTc, expIrq}));
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeWord(input logic [8:0] d);
    @(negedge clk); statusRd = 1;
    @(negedge clk); statusRd = 0; wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic finish();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish();
    end
  end

  initial begin
    waitClk(3);
    phase = "R1";
    check(dataEmpty === 1 && txDone === 1 && txLine === 1 && txDriveEn === 0 && irq === 0,
          "R1", $sformatf("%b", {dataEmpty, txDone, txLine, txDriveEn, irq}), "11100");
    @(negedge clk); rstN = 1;
    waitClk(4);
    check(dataEmpty === 1 && txDone === 1 && txDriveEn === 0, "R1",
          $sformatf("%b", {dataEmpty, txDone, txDriveEn}), "110");

    phase = "R6"; txEnable = 1; waitClk(50);
    check(txLine === 1 && txDriveEn === 1, "R6", $sformatf("%b", {txLine, txDriveEn}), "11");

    phase = "R2"; writeWord(9'h0A5); waitClk(50);
    longWord = 1; writeWord(9'h1C3); waitClk(55);
    check(dataEmpty === 1 && txDone === 1, "R5", $sformatf("%b", {dataEmpty, txDone}), "11");

    phase = "R3"; longWord = 0;
    @(negedge clk); wrEn = 1; wrData = 9'h055; @(negedge clk); wrEn = 0;
    waitClk(20);
    check(dataEmpty === 1 && txLine === 1, "R3", $sformatf("%b", {dataEmpty, txLine}), "11");

    phase = "R4"; writeWord(9'h00F); writeWord(9'h0F0);
    check(dataEmpty === 0, "R4", $sformatf("%b", dataEmpty), "0");
    waitClk(100);

    phase = "R9"; writeWord(9'h033); waitClk(6);
    @(negedge clk); sendBreak = 1; @(negedge clk); sendBreak = 0;
    waitClk(120);

    phase = "R8"; sendBreak = 1; waitClk(110); sendBreak = 0;
    phase = "R10"; waitClk(60);

    phase = "R11"; writeWord(9'h081); waitClk(6);
    @(negedge clk); txEnable = 0; @(negedge clk); txEnable = 1;
    @(negedge clk); sendBreak = 1; @(negedge clk); sendBreak = 0;
    writeWord(9'h07E);
    waitClk(200);

    phase = "R7"; writeWord(9'h0C3); waitClk(10);
    @(negedge clk); txEnable = 0;
    check(txDriveEn === 1, "R7", $sformatf("%b", txDriveEn), "1");
    waitClk(60);
    check(txDriveEn === 0 && txLine === 1, "R7", $sformatf("%b", {txDriveEn, txLine}), "01");

    phase = "R12"; txIntEn = 1; waitClk(2);
    check(irq === 1, "R12", $sformatf("%b", irq), "1");
    txIntEn = 0; doneIntEn = 1; writeWord(9'h011); waitClk(2);
    check(irq === 0, "R12", $sformatf("%b", irq), "0");
    txEnable = 1; waitClk(120);
    check(irq === 1, "R12", $sformatf("%b", irq), "1");
    waitClk(4);
    finish();
  end
endmodule